// File: doc/BRIEF.md
# Key-Protected Halt Control Register

This block is one word-wide control and status register in a processor debug unit. It sits on a simple register bus (address, write strobe, write data, read strobe, read data) and answers at one word address. Through it a debugger turns halting debug on, asks the core to halt, enables single stepping and masks interrupts while stepping. The four control bits drive outputs toward the core.

Every write must carry a fixed 16-bit key in the upper half-word. A write without the key changes nothing. A read returns the control bits, four level status inputs from the core, and three sticky event flags. The flags record a core reset, instruction retirement and a processed restart. Reading the register clears them. An event that arrives in the same cycle as the read still leaves its flag set.

Top module: `dbg_halt_ctl`

## Requirements
- R1: After reset, all four control outputs are 0 and a read of the register returns 0x0000_0000.
- R2: A write to address 0x10 whose data bits 31:16 differ from 0xA05F changes no control output. A write to any other address also changes none.
- R3: A write to 0x10 that carries the key 0xA05F in bits 31:16 loads the control outputs on the next clock edge. Bit 0 drives debug enable, bit 1 the halt request, bit 2 step enable and bit 3 the interrupt mask (bit 3 is limited by R4).
- R4: The interrupt mask changes only if debug enable is already 1, or if the same keyed write sets bit 0. Otherwise the mask keeps its value.
- R5: While the read strobe is high and the address is 0x10, read data shows the following in the same cycle: the controls in bits 3:0, halted in bit 17, sleeping in bit 18, lockup in bit 19 and secure-debug-allowed in bit 20. Bits 31:27, 23:21 and 16:4 read 0. This includes the imprecise-entry bit 5 and the key field.
- R6: A pulse on the retire, core-reset or restart event input sets bit 24, 25 or 26 of the read data respectively, from the next cycle on. The bit stays set until the register is read.
- R7: A read of address 0x10 clears bits 26:24 at the end of the read cycle. The read itself still returns the old values. If an event arrives in the read cycle, its bit stays set.
- R8: A keyed write that takes the halt request from 1 to 0 sets restart bit 26. A keyed write with bit 1 at 0 while the halt request is already 0 does not set it.
- R9: An external restart pulse sets restart bit 26. It also forces the halt request to 0 on the next edge, even if a keyed write in the same cycle sets bit 1.
- R10: Read data is 0 whenever the read strobe is low or the address is not 0x10. A read at another address leaves the sticky bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register word byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, key in bits 31:16 |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| core_halted | input | 1 | Core is in debug state |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is in lockup |
| core_sec_dbg_ok | input | 1 | Secure invasive debug allowed |
| ev_retire | input | 1 | Core retired one or more instructions |
| ev_core_reset | input | 1 | Core was reset |
| ev_ext_restart | input | 1 | External restart request |
| ctl_dbg_en | output | 1 | Halting debug enable |
| ctl_halt_req | output | 1 | Halt request |
| ctl_step | output | 1 | Single-step enable |
| ctl_mask_ints | output | 1 | Interrupt mask during debug |

## Verification
A wrong control flop shows on its output pin one cycle after the write that set it, and again in bits 3:0 of the next read. A missed or early flag clear shows on the very next read of the register. This holds because read data is combinational and every read exposes all three flags. Random mixes of keyed and unkeyed writes, reads, events and restarts are compared every cycle against a bench model. A fault in the key gate, the mask gate or the flag set-clear priority therefore shows up within a few cycles.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned KEY_W    = 16;
   localparam int unsigned NUM_CTL  = 4;
   localparam int unsigned NUM_FLAG = 3;

   // control bit positions
   localparam int unsigned B_DBG_EN = 0;
   localparam int unsigned B_HALT   = 1;
   localparam int unsigned B_STEP   = 2;
   localparam int unsigned B_MASK   = 3;

   // status and flag base positions
   localparam int unsigned B_STAT0  = 17;
   localparam int unsigned B_FLAG0  = 24;

   // sticky flag indices (flag i reads at B_FLAG0 + i)
   typedef enum logic [1:0] {
      FL_RETIRE  = 2'd0,
      FL_RESET   = 2'd1,
      FL_RESTART = 2'd2
   } flag_idx_e;

   typedef struct packed {
      logic mask;
      logic step;
      logic halt;
      logic dbg_en;
   } ctl_t;
endpackage

// File: rtl/dbg_halt_decode.sv
module dbg_halt_decode #(
   parameter int unsigned ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] OFFSET = 8'h10,
   parameter int unsigned KEY_W      = 16,
   parameter logic [KEY_W-1:0] KEY   = 16'hA05F
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [KEY_W-1:0]  key_field,
   output logic              wr_ok,
   output logic              rd_hit
);
   logic hit;

   always_comb begin
      hit    = (addr == OFFSET);
      wr_ok  = wr && hit && (key_field == KEY);
      rd_hit = rd && hit;
   end
endmodule

// File: rtl/dbg_halt_ctlreg.sv
module dbg_halt_ctlreg
   import dbg_halt_pkg::*;
#(
   parameter bit MASK_GATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ok,
   input  logic [NUM_CTL-1:0] wbits,
   input  logic               ext_restart,
   output ctl_t               ctl,
   output logic               restart_ev
);
   ctl_t ctl_q;
   logic mask_en;

   generate
      if (MASK_GATE) begin : g_gated
         always_comb mask_en = ctl_q.dbg_en | wbits[B_DBG_EN];
      end else begin : g_open
         always_comb mask_en = 1'b1;
      end
   endgenerate

   always_comb begin
      restart_ev = ext_restart | (wr_ok & ctl_q.halt & ~wbits[B_HALT]);
      ctl        = ctl_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (wr_ok) begin
            ctl_q.dbg_en <= wbits[B_DBG_EN];
            ctl_q.halt   <= wbits[B_HALT];
            ctl_q.step   <= wbits[B_STEP];
            if (mask_en) ctl_q.mask <= wbits[B_MASK];
         end
         if (ext_restart) ctl_q.halt <= 1'b0;
      end
   end

   // R4: mask is frozen without debug enable
   a_r4_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (MASK_GATE && !ctl_q.dbg_en && !(wr_ok && wbits[B_DBG_EN])) |=> $stable(ctl_q.mask));

   // R9: external restart drops the halt request
   a_r9_restart_clears_halt: assert property (@(posedge clk) disable iff (!rst_n)
      ext_restart |=> !ctl_q.halt);
endmodule

// File: rtl/dbg_sticky_flag.sv
module dbg_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag & ~clr) | ev;
   end

   // R6: held until read
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   // R7: event in the read cycle wins
   a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev |=> flag);
   // R7: read without event clears
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ev) |=> !flag);
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
   import dbg_halt_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter logic [ADDR_W-1:0] OFFSET = 8'h10,
   parameter logic [KEY_W-1:0] KEY     = 16'hA05F,
   parameter bit MASK_GATE             = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              core_halted,
   input  logic              core_sleeping,
   input  logic              core_lockup,
   input  logic              core_sec_dbg_ok,
   input  logic              ev_retire,
   input  logic              ev_core_reset,
   input  logic              ev_ext_restart,
   output logic              ctl_dbg_en,
   output logic              ctl_halt_req,
   output logic              ctl_step,
   output logic              ctl_mask_ints
);
   localparam int unsigned NUM_STAT = 4;

   generate
      if (KEY_W * 2 != DATA_W) begin : g_bad_key
         $error("key must fill the upper half-word");
      end
      if (B_FLAG0 + NUM_FLAG > DATA_W || B_STAT0 + NUM_STAT > B_FLAG0) begin : g_bad_map
         $error("field map overlaps or overflows the word");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("address too narrow for the register offset");
      end
   endgenerate

   logic                wr_ok, rd_hit, restart_ev;
   ctl_t                ctl;
   logic [NUM_FLAG-1:0] ev_vec, flags;
   logic [NUM_STAT-1:0] stat;

   dbg_halt_decode #(
      .ADDR_W(ADDR_W), .OFFSET(OFFSET), .KEY_W(KEY_W), .KEY(KEY)
   ) u_dec (
      .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .key_field(bus_wdata[DATA_W-1 -: KEY_W]),
      .wr_ok(wr_ok), .rd_hit(rd_hit)
   );

   dbg_halt_ctlreg #(.MASK_GATE(MASK_GATE)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
      .wbits(bus_wdata[NUM_CTL-1:0]), .ext_restart(ev_ext_restart),
      .ctl(ctl), .restart_ev(restart_ev)
   );

   always_comb begin
      ev_vec              = '0;
      ev_vec[FL_RETIRE]   = ev_retire;
      ev_vec[FL_RESET]    = ev_core_reset;
      ev_vec[FL_RESTART]  = restart_ev;
      stat = {core_sec_dbg_ok, core_lockup, core_sleeping, core_halted};
   end

   for (genvar i = 0; i < NUM_FLAG; i++) begin : g_flag
      dbg_sticky_flag u_flag (
         .clk(clk), .rst_n(rst_n), .ev(ev_vec[i]), .clr(rd_hit), .flag(flags[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         bus_rdata[B_DBG_EN] = ctl.dbg_en;
         bus_rdata[B_HALT]   = ctl.halt;
         bus_rdata[B_STEP]   = ctl.step;
         bus_rdata[B_MASK]   = ctl.mask;
         bus_rdata[B_STAT0 +: NUM_STAT] = stat;
         bus_rdata[B_FLAG0 +: NUM_FLAG] = flags;
      end
      ctl_dbg_en    = ctl.dbg_en;
      ctl_halt_req  = ctl.halt;
      ctl_step      = ctl.step;
      ctl_mask_ints = ctl.mask;
   end

   // R2: no key, no change
   a_r2_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ok && !ev_ext_restart)
      |=> $stable({ctl_dbg_en, ctl_halt_req, ctl_step, ctl_mask_ints}));

   // R8: keyed halt clear sets restart flag
   a_r8_halt_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && ctl_halt_req && !bus_wdata[B_HALT]) |=> flags[FL_RESTART]);

   // R10: foreign reads leave flags alone
   a_r10_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != OFFSET && !ev_retire && !ev_core_reset && !ev_ext_restart)
      |=> $stable(flags));
endmodule

// File: tb/tb_dbg_halt_ctl.sv
module tb_dbg_halt_ctl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic core_halted = 0, core_sleeping = 0, core_lockup = 0, core_sec_dbg_ok = 0;
   logic ev_retire = 0, ev_core_reset = 0, ev_ext_restart = 0;
   logic ctl_dbg_en, ctl_halt_req, ctl_step, ctl_mask_ints;

   int checks = 0, errors = 0;
   bit done = 0;

   // bench model
   logic m_dbg = 0, m_halt = 0, m_step = 0, m_mask = 0;
   logic f_ret = 0, f_rst = 0, f_rs = 0;

   always #5 clk = ~clk;

   dbg_halt_ctl dut (.*);

   function automatic logic [31:0] exp_rdata();
      logic [31:0] d = '0;
      if (bus_rd && bus_addr == 8'h10) begin
         d[3:0]   = {m_mask, m_step, m_halt, m_dbg};
         d[20:17] = {core_sec_dbg_ok, core_lockup, core_sleeping, core_halted};
         d[26:24] = {f_rs, f_rst, f_ret};
      end
      return d;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one bus cycle: drive at negedge, check, then advance the model
   task automatic cyc(string tag, logic [7:0] a, logic w, logic [31:0] wd, logic r,
                      logic [3:0] st, logic [2:0] ev);
      logic hit, wok, rdh, rs_ev;
      @(negedge clk);
      bus_addr = a; bus_wr = w; bus_wdata = wd; bus_rd = r;
      {core_sec_dbg_ok, core_lockup, core_sleeping, core_halted} = st;
      {ev_ext_restart, ev_core_reset, ev_retire} = ev;
      #1;
      chk({tag, " ctl R3 R4 R9"}, {28'd0, ctl_mask_ints, ctl_step, ctl_halt_req, ctl_dbg_en},
          {28'd0, m_mask, m_step, m_halt, m_dbg});
      chk({tag, " rdata R5 R6 R7 R10"}, bus_rdata, exp_rdata());
      hit = (a == 8'h10); wok = w && hit && (wd[31:16] == 16'hA05F); rdh = r && hit;
      rs_ev = ev[2] | (wok & m_halt & ~wd[1]);
      f_ret = (f_ret & ~rdh) | ev[0];
      f_rst = (f_rst & ~rdh) | ev[1];
      f_rs  = (f_rs  & ~rdh) | rs_ev;
      if (wok) begin
         if (m_dbg | wd[0]) m_mask = wd[3];
         m_dbg = wd[0]; m_halt = wd[1]; m_step = wd[2];
      end
      if (ev[2]) m_halt = 1'b0;
   endtask

   task automatic idle(string tag);
      cyc(tag, 8'h00, 0, 32'h0, 0, 4'h0, 3'b000);
   endtask

   initial begin
      #100000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state and reset read
      cyc("R1 reset read", 8'h10, 0, 0, 1, 4'h0, 3'b000);
      chk("R1 reset ctl", {28'd0, ctl_mask_ints, ctl_step, ctl_halt_req, ctl_dbg_en}, 32'd0);
      // R2 wrong key, wrong address
      cyc("R2 bad key", 8'h10, 1, 32'h1234_000F, 0, 4'h0, 3'b000);
      cyc("R2 bad addr", 8'h14, 1, 32'hA05F_000F, 0, 4'h0, 3'b000);
      idle("R2 after");
      chk("R2 no change", {28'd0, ctl_mask_ints, ctl_step, ctl_halt_req, ctl_dbg_en}, 32'd0);
      // R4 mask blocked without debug enable
      cyc("R4 blocked", 8'h10, 1, 32'hA05F_0008, 0, 4'h0, 3'b000);
      idle("R4 after");
      chk("R4 mask stays 0", {31'd0, ctl_mask_ints}, 32'd0);
      // R3 full keyed write incl. mask with enable in same write
      cyc("R3 write", 8'h10, 1, 32'hA05F_FFFF, 0, 4'h0, 3'b000);
      idle("R3 after");
      chk("R3 ctl all set", {28'd0, ctl_mask_ints, ctl_step, ctl_halt_req, ctl_dbg_en}, 32'hF);
      // R5 read layout, bit 5 and key zero
      cyc("R5 read", 8'h10, 0, 0, 1, 4'hF, 3'b000);
      chk("R5 layout", bus_rdata, 32'h001E_000F);
      // R8 keyed halt clear sets restart flag
      cyc("R8 clear halt", 8'h10, 1, 32'hA05F_0001, 0, 4'h0, 3'b000);
      cyc("R8 read", 8'h10, 0, 0, 1, 4'h0, 3'b000);
      chk("R8 restart flag", bus_rdata & 32'h0700_0000, 32'h0400_0000);
      cyc("R8 no-op clear", 8'h10, 1, 32'hA05F_0001, 0, 4'h0, 3'b000);
      cyc("R8 read2", 8'h10, 0, 0, 1, 4'h0, 3'b000);
      chk("R8 no flag", bus_rdata & 32'h0700_0000, 32'h0);
      // R9 ext restart beats keyed halt set
      cyc("R9 set halt", 8'h10, 1, 32'hA05F_0003, 0, 4'h0, 3'b000);
      cyc("R9 race", 8'h10, 1, 32'hA05F_0003, 0, 4'h0, 3'b100);
      idle("R9 after");
      chk("R9 halt cleared", {31'd0, ctl_halt_req}, 32'd0);
      // R6 events, R10 foreign read keeps them
      cyc("R6 events", 8'h00, 0, 0, 0, 4'h0, 3'b011);
      cyc("R10 foreign read", 8'h14, 0, 0, 1, 4'h0, 3'b000);
      chk("R10 rdata zero", bus_rdata, 32'd0);
      cyc("R6 read", 8'h10, 0, 0, 1, 4'h0, 3'b001);
      chk("R6 flags", bus_rdata & 32'h0700_0000, 32'h0700_0000);
      // R7 retire came during read: stays; others cleared
      cyc("R7 read", 8'h10, 0, 0, 1, 4'h0, 3'b000);
      chk("R7 event wins", bus_rdata & 32'h0700_0000, 32'h0100_0000);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] a;
         logic [31:0] wd;
         logic [2:0] ev;
         a  = ($urandom % 4 != 0) ? 8'h10 : 8'($urandom);
         wd = $urandom;
         if ($urandom % 3 != 0) wd[31:16] = 16'hA05F;
         ev = 3'($urandom) & 3'($urandom);
         cyc("random", a, 1'($urandom % 3 == 0), wd, 1'($urandom % 3 == 0),
             4'($urandom), ev);
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule